// File: doc/BRIEF.md
# Predecoded Enable AND-OR Bus Selector

This block picks one of eight equal-width data words and presents it on a single output bus. It does not use a binary multiplexer tree driven by the select code, and it does not use a chain of prioritised conditions. The 3-bit select is first turned into eight one-hot enables. Each data word is masked by its own enable. The masked words are merged with OR in two levels: adjacent pairs first, then a four-way OR of the pair results. Because at most one enable is ever high, the merge is exact and no input has precedence over another. A disable input drops every enable, so the output is all zeros.

A second, registered path is selected with `reg_mode`. Each input then has its own source register. The decoder's enables act as the synchronous clears of those registers: on every clock edge, each register whose enable is low is cleared. Nothing else sits in front of a register except a plain load strobe. The output is then a bare OR of all eight registers. A change of select therefore appears one clock later, once the registers that are no longer selected have been cleared.

Top module: `enable_andor_mux`

## Requirements
- R1: With `reg_mode`=0 and `mux_off`=0, `y` equals data word k in the same cycle, where k is the value of `sel` and word k occupies `din[k*W +: W]`.
- R2: With `reg_mode`=0 and `mux_off`=1, `y` is all zeros in the same cycle, whatever `sel` and `din` hold.
- R3: The internal enable vector never has more than one bit set, and the selected word reaches `y` without being ORed with any other word.
- R4: With `reg_mode`=1, a clock edge with `load`=1 and `mux_off`=0 stores word `sel` in its source register, and `y` shows that word after the edge.
- R5: With `reg_mode`=1, each clock edge clears every source register that is not selected. After `sel` changes with `load`=0, `y` keeps the old word until the next edge and is zero after it.
- R6: With `reg_mode`=1, `load`=0 and `sel` unchanged, `y` holds its value across edges even while `din` changes.
- R7: With `reg_mode`=1, an edge with `mux_off`=1 clears every source register, even when `load`=1, so `y` is zero after the edge.
- R8: A clock edge with `rst_n`=0 clears every source register, so `y` is zero in the registered path after reset.
- R9: When `sel` changes and `load`=1 on the same edge, the old source is cleared and the new word is stored together, so `y` shows the new word after that single edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the source registers |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_mode | input | 1 | 0: direct AND-OR path; 1: output is the OR of the source registers |
| mux_off | input | 1 | Forces every enable low |
| load | input | 1 | Source-load strobe for the selected register |
| sel | input | SEL_W (3) | Binary index of the chosen word |
| din | input | W*8 | Eight data words; word k at bits [k*W +: W] |
| y | output | W | Selected word |

## Verification
In the registered path, the decoder clearing the old source and the load strobe filling the new source can land on one clock edge. The bench provokes this by changing `sel` and raising `load` in the same cycle. It expects the new word after exactly one edge, with no trace of the old word ORed into it. A second overlap drives `mux_off` and `load` together. The clear must win, and `y` is checked for zero after the edge.

// File: rtl/emux_pkg.sv
package emux_pkg;

    typedef enum logic {
        PATH_DIRECT     = 1'b0,
        PATH_REGISTERED = 1'b1
    } emux_path_e;

    function automatic int unsigned emux_inputs(input int unsigned sel_w);
        return 32'd1 << sel_w;
    endfunction

endpackage

// File: rtl/emux_decode.sv
module emux_decode #(
    parameter int unsigned SEL_W = 3,
    localparam int unsigned N_IN = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             off,
    output logic [N_IN-1:0]  en
);
    for (genvar i = 0; i < N_IN; i++) begin : g_dec
        assign en[i] = !off && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/emux_src_bank.sv
module emux_src_bank #(
    parameter int unsigned W    = 16,
    parameter int unsigned N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [N_IN-1:0] en,
    input  logic [N_IN*W-1:0] d,
    output logic [N_IN*W-1:0] q
);
    for (genvar i = 0; i < N_IN; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i*W +: W] <= '0;
            end else if (!en[i]) begin
                q[i*W +: W] <= '0;
            end else if (load) begin
                q[i*W +: W] <= d[i*W +: W];
            end
        end
    end
endmodule

// File: rtl/emux_andor.sv
module emux_andor #(
    parameter int unsigned W    = 16,
    parameter int unsigned N_IN = 8,
    localparam int unsigned PAIRS = N_IN / 2
) (
    input  logic [N_IN-1:0]   en,
    input  logic [N_IN*W-1:0] d,
    output logic [W-1:0]      y
);
    logic [PAIRS*W-1:0] pair_or;

    for (genvar j = 0; j < PAIRS; j++) begin : g_lvl1
        assign pair_or[j*W +: W] =
            ({W{en[2*j]}}   & d[(2*j)*W   +: W]) |
            ({W{en[2*j+1]}} & d[(2*j+1)*W +: W]);
    end

    always_comb begin
        y = '0;
        for (int j = 0; j < PAIRS; j++) begin
            y = y | pair_or[j*W +: W];
        end
    end
endmodule

// File: rtl/enable_andor_mux.sv
module enable_andor_mux
    import emux_pkg::*;
#(
    parameter int unsigned W     = 16,
    parameter int unsigned SEL_W = 3,
    localparam int unsigned N_IN = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_mode,
    input  logic              mux_off,
    input  logic              load,
    input  logic [SEL_W-1:0]  sel,
    input  logic [N_IN*W-1:0] din,
    output logic [W-1:0]      y
);
    emux_path_e          path;
    logic [N_IN-1:0]     en_vec;
    logic [N_IN*W-1:0]   src_q;
    logic [N_IN-1:0]     merge_en;
    logic [N_IN*W-1:0]   merge_d;

    assign path = reg_mode ? PATH_REGISTERED : PATH_DIRECT;

    emux_decode #(.SEL_W(SEL_W)) u_dec (
        .sel (sel),
        .off (mux_off),
        .en  (en_vec)
    );

    emux_src_bank #(.W(W), .N_IN(N_IN)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .en    (en_vec),
        .d     (din),
        .q     (src_q)
    );

    always_comb begin
        unique case (path)
            PATH_DIRECT: begin
                merge_en = en_vec;
                merge_d  = din;
            end
            PATH_REGISTERED: begin
                merge_en = '1;
                merge_d  = src_q;
            end
            default: begin
                merge_en = '0;
                merge_d  = '0;
            end
        endcase
    end

    emux_andor #(.W(W), .N_IN(N_IN)) u_merge (
        .en (merge_en),
        .d  (merge_d),
        .y  (y)
    );
endmodule

// File: rtl/emux_checker.sv
module emux_checker #(
    parameter int unsigned W     = 16,
    parameter int unsigned SEL_W = 3,
    localparam int unsigned N_IN = 1 << SEL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_mode,
    input logic              mux_off,
    input logic              load,
    input logic [SEL_W-1:0]  sel,
    input logic [N_IN*W-1:0] din,
    input logic [W-1:0]      y,
    input logic [N_IN-1:0]   en_vec,
    input logic [N_IN*W-1:0] src_q
);
    logic [W-1:0]    picked;
    logic [N_IN-1:0] nz;

    always_comb begin
        picked = din[sel*W +: W];
        for (int i = 0; i < N_IN; i++) nz[i] = |src_q[i*W +: W];
    end

    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_vec));

    p_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_mode && !mux_off) |-> y == picked);

    p_off_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_mode && mux_off) |-> y == '0);

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mode && load && !mux_off) ##1 reg_mode |-> y == $past(picked));

    p_single_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(nz) <= 1);

    p_off_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mux_off |=> nz == '0);
endmodule

bind enable_andor_mux emux_checker #(.W(W), .SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_mode (reg_mode),
    .mux_off  (mux_off),
    .load     (load),
    .sel      (sel),
    .din      (din),
    .y        (y),
    .en_vec   (en_vec),
    .src_q    (src_q)
);

// File: tb/test_enable_andor_mux.sv
module test_enable_andor_mux;
    localparam int W = 16;
    localparam int SEL_W = 3;
    localparam int N_IN = 8;
    localparam time CYC = 8ns;

    typedef struct packed {
        logic [2:0]  sel;
        logic        off;
        logic [15:0] seed;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{3'd0, 1'b0, 16'h1234}, '{3'd1, 1'b0, 16'hBEEF},
        '{3'd2, 1'b0, 16'h0F0F}, '{3'd3, 1'b0, 16'hFFFF},
        '{3'd4, 1'b0, 16'h8001}, '{3'd5, 1'b0, 16'h5A5A},
        '{3'd6, 1'b0, 16'h0000}, '{3'd7, 1'b0, 16'hC3C3},
        '{3'd3, 1'b1, 16'hFFFF}, '{3'd7, 1'b1, 16'h7777}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_mode = 1'b0;
    logic mux_off = 1'b0;
    logic load = 1'b0;
    logic [SEL_W-1:0] sel = '0;
    logic [N_IN*W-1:0] din = '0;
    logic [W-1:0] y;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CYC/2) clk = ~clk;

    enable_andor_mux #(.W(W), .SEL_W(SEL_W)) i_enable_andor_mux (
        .clk(clk), .rst_n(rst_n), .reg_mode(reg_mode), .mux_off(mux_off),
        .load(load), .sel(sel), .din(din), .y(y)
    );

    function automatic logic [N_IN*W-1:0] fill(input logic [15:0] seed);
        logic [N_IN*W-1:0] r;
        for (int k = 0; k < N_IN; k++) r[k*W +: W] = seed ^ {4{4'(k + 1)}};
        return r;
    endfunction

    function automatic logic [W-1:0] ref_mux(input logic [N_IN*W-1:0] d,
                                             input logic [2:0] s, input logic off);
        if (off) return '0;
        case (s)
            3'd0: return d[0*W +: W];
            3'd1: return d[1*W +: W];
            3'd2: return d[2*W +: W];
            3'd3: return d[3*W +: W];
            3'd4: return d[4*W +: W];
            3'd5: return d[5*W +: W];
            3'd6: return d[6*W +: W];
            default: return d[7*W +: W];
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #(CYC * 20000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [N_IN*W-1:0] pat;
        logic [N_IN*W-1:0] pat2;
        // R8: reset clears the sources, visible on the registered path
        reg_mode = 1'b1;
        din = fill(16'hFACE);
        load = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 reset", y, '0);
        rst_n = 1'b1;
        load = 1'b0;

        // R1 R2 R3: vector table on the direct path
        @(negedge clk);
        reg_mode = 1'b0;
        foreach (VECS[v]) begin
            din = fill(VECS[v].seed);
            sel = VECS[v].sel;
            mux_off = VECS[v].off;
            #1;
            check(VECS[v].off ? "R2 off" : "R1 R3 pick", y,
                  ref_mux(din, VECS[v].sel, VECS[v].off));
            @(negedge clk);
        end
        mux_off = 1'b0;

        // R1 R3: random data across every select value
        for (int r = 0; r < 64; r++) begin
            for (int k = 0; k < N_IN; k++) din[k*W +: W] = W'($urandom);
            sel = 3'(r);
            #1;
            check("R1 R3 random", y, ref_mux(din, sel, 1'b0));
            @(negedge clk);
        end

        // R4: load into the selected source
        reg_mode = 1'b1;
        pat = fill(16'h3C00);
        din = pat;
        sel = 3'd2;
        load = 1'b1;
        @(negedge clk);
        check("R4 load", y, pat[2*W +: W]);

        // R6: hold without load while data moves
        load = 1'b0;
        din = fill(16'h00AA);
        @(negedge clk);
        @(negedge clk);
        check("R6 hold", y, pat[2*W +: W]);

        // R5: select change without load
        sel = 3'd5;
        #1;
        check("R5 before edge", y, pat[2*W +: W]);
        @(negedge clk);
        check("R5 after edge", y, '0);

        // R9: select change and load on one edge
        sel = 3'd2;
        load = 1'b1;
        pat = fill(16'h9999);
        din = pat;
        @(negedge clk);
        check("R9 reload", y, pat[2*W +: W]);
        pat2 = fill(16'h4321);
        din = pat2;
        sel = 3'd6;
        @(negedge clk);
        check("R9 switch", y, pat2[6*W +: W]);

        // R7: disable wins over load
        mux_off = 1'b1;
        @(negedge clk);
        check("R7 off", y, '0);
        mux_off = 1'b0;
        load = 1'b0;
        @(negedge clk);
        check("R7 stays cleared", y, '0);

        // R8: reset in the middle of operation
        load = 1'b1;
        sel = 3'd7;
        @(negedge clk);
        check("R4 load idx7", y, pat2[7*W +: W]);
        load = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 mid reset", y, '0);
        rst_n = 1'b1;

        // R2: direct path disable with all-ones data
        reg_mode = 1'b0;
        din = '1;
        mux_off = 1'b1;
        #1;
        check("R2 off ones", y, '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule